// File: doc/BRIEF.md
# Bubble-Tolerant Delay-Line Edge Encoder

This block turns the sampled snapshot of a tapped delay line into the binary position of the signal edge inside that snapshot. The snapshot comes from an upstream register, so it is already synchronous. It may not be a clean thermometer code: near the edge, metastable or unevenly timed taps leave bubbles, which are isolated wrong bits. The encoder removes these bubbles with a row of pattern cells. Each cell looks at one tap and at the four taps after it, and the row produces a one-hot style vector. A second stage then converts that vector to a number. It does this with a running adder: every position before the first detected bit adds one, and every later position adds zero.

A polarity input selects which kind of edge is being measured. Edges from a high-to-low wave front are reported in the lower code half. Edges from the opposite front are reported in the upper half, offset by a fixed span (256 by default). With the default span the combined range is 0 to 511, carried in a 16-bit output. The adder is split into segments and registered, so the block accepts a new snapshot on every cycle and returns each result a fixed number of cycles later.

Top module: `bubble_edge_encoder`

## Requirements
- R1: With polarity 0, detector cell i fires when tap i is 1 and taps i+1 to i+4 are all 0. Positions past the last tap count as 0, so a 1 on the last tap fires its cell.
- R2: A bubble is a stray bit near the transition. A cell whose four following taps are not all 0 does not fire, so the reported edge is the 1 that is followed by four clear taps, not the earlier one.
- R3: When several cells fire in one snapshot, the result is the lowest firing index.
- R4: When a cell fires, edge_num_o equals the index of the lowest firing cell plus the polarity offset, and edge_vld_o is 1.
- R5: When no cell fires, edge_num_o equals NTAPS plus the polarity offset, and edge_vld_o is 0.
- R6: With polarity 1, the taps are inverted before detection, so an edge made of zeros followed by ones is found. POL_OFFSET (default 256) is then added, which places these edges in 256..511.
- R7: A snapshot presented before clock edge k produces its result after clock edge k+2, which is three register stages. A new snapshot is accepted on every cycle with no gaps.
- R8: During reset and until the first result arrives, the outputs show the no-edge code: edge_num_o equals NTAPS and edge_vld_o is 0.
- R9: edge_num_o is 16 bits wide. Every bit above the encoded value is 0, so no code exceeds 2*POL_OFFSET-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps_i | input | NTAPS | Registered delay-line snapshot, index 0 is nearest the launch point |
| pol_i | input | 1 | Edge polarity: 0 finds ones followed by zeros, 1 finds zeros followed by ones |
| edge_num_o | output | OUT_W (16) | Encoded edge position including the polarity offset |
| edge_vld_o | output | 1 | Set when the snapshot contained a detectable edge |

## Verification
Bubble rejection and lowest-index priority can both act on the same snapshot. In that case a pattern holds a true edge, a bubble that stops an earlier cell from firing, and a second clean edge further along, all at once. The bench provokes this by sweeping every tap pattern of a 12-tap configuration in both polarities, with a new snapshot on each cycle. It judges each three-stage-delayed result against a position computed independently from the cell rule. Directed patterns also place a bubble and a second edge side by side to name the interaction explicitly.

// File: rtl/bte_pkg.sv
`timescale 1ns/1ps
package bte_pkg;
  // Number of taps one detector cell examines: its own tap plus the four that follow.
  localparam int unsigned DET_SPAN = 5;

  // Rule for one detector cell: the tap is high and the four following taps are low.
  function automatic logic det_cell(input logic [DET_SPAN-1:0] w);
    return w[0] & ~w[1] & ~w[2] & ~w[3] & ~w[4];
  endfunction
endpackage

// File: rtl/bte_detect.sv
`timescale 1ns/1ps
module bte_detect #(
  parameter int unsigned NTAPS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps_i,
  input  logic             pol_i,
  output logic [NTAPS-1:0] hot_q,
  output logic             pol_q
);
  import bte_pkg::*;

  localparam int unsigned PAD = DET_SPAN - 1;

  logic [NTAPS-1:0]     norm;
  logic [NTAPS+PAD-1:0] padded;
  logic [NTAPS-1:0]     fire;

  assign norm   = pol_i ? ~taps_i : taps_i;
  assign padded = {{PAD{1'b0}}, norm};

  for (genvar g = 0; g < NTAPS; g++) begin : g_cell
    assign fire[g] = det_cell(padded[g+PAD:g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= '0;
      pol_q <= 1'b0;
    end else begin
      hot_q <= fire;
      pol_q <= pol_i;
    end
  end

  // R1 / R2: a firing cell needs four clear taps after it, so no other cell
  // can fire within the next four positions.
  for (genvar g = 0; g < NTAPS - 1; g++) begin : g_spc
    localparam int unsigned HI = (g + PAD < NTAPS - 1) ? g + PAD : NTAPS - 1;
    assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q[g] |-> (hot_q[HI:g+1] == '0));
  end
endmodule

// File: rtl/bte_segcount.sv
`timescale 1ns/1ps
module bte_segcount #(
  parameter int unsigned NTAPS = 32,
  parameter int unsigned SEG_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NTAPS-1:0]               hot_i,
  input  logic                           pol_i,
  output logic [NTAPS/SEG_W-1:0][$clog2(SEG_W+1)-1:0] seg_cnt_q,
  output logic [NTAPS/SEG_W-1:0]         seg_hit_q,
  output logic                           pol_q
);
  localparam int unsigned NSEG   = NTAPS / SEG_W;
  localparam int unsigned SEG_CW = $clog2(SEG_W + 1);

  // Running adder within one segment: each position before the first set bit
  // adds 01, each position at or after it adds 00.
  function automatic logic [SEG_CW-1:0] seg_lead(input logic [SEG_W-1:0] v);
    logic [SEG_CW-1:0] n;
    logic              seen;
    n    = '0;
    seen = 1'b0;
    for (int i = 0; i < SEG_W; i++) begin
      if (v[i]) seen = 1'b1;
      n = n + (seen ? SEG_CW'(0) : SEG_CW'(1));
    end
    return n;
  endfunction

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] slice;
    assign slice = hot_i[s*SEG_W +: SEG_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_cnt_q[s] <= SEG_CW'(SEG_W);
        seg_hit_q[s] <= 1'b0;
      end else begin
        seg_cnt_q[s] <= seg_lead(slice);
        seg_hit_q[s] <= |slice;
      end
    end

    // R4: a segment that holds a hit counts fewer positions than its width.
    assert_seg_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seg_hit_q[s] |-> (seg_cnt_q[s] < SEG_CW'(SEG_W)));
    // R5: an empty segment contributes its full width.
    assert_seg_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_hit_q[s] |-> (seg_cnt_q[s] == SEG_CW'(SEG_W)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_i;
  end
endmodule

// File: rtl/bubble_edge_encoder.sv
`timescale 1ns/1ps
module bubble_edge_encoder #(
  parameter int unsigned NTAPS      = 32,
  parameter int unsigned SEG_W      = 8,
  parameter int unsigned POL_OFFSET = 256,
  parameter int unsigned OUT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps_i,
  input  logic             pol_i,
  output logic [OUT_W-1:0] edge_num_o,
  output logic             edge_vld_o
);
  localparam int unsigned NSEG   = NTAPS / SEG_W;
  localparam int unsigned SEG_CW = $clog2(SEG_W + 1);
  localparam logic [OUT_W-1:0] NO_EDGE = OUT_W'(NTAPS);
  localparam logic [OUT_W-1:0] OFFSET  = OUT_W'(POL_OFFSET);

  // Stage 1 to 2 event wires
  logic [NTAPS-1:0]              hot;
  logic                          pol_s1;
  logic [NSEG-1:0][SEG_CW-1:0]   seg_cnt;
  logic [NSEG-1:0]               seg_hit;
  logic                          pol_s2;
  logic [OUT_W-1:0]              total;
  logic                          any_hit;

  bte_detect #(.NTAPS(NTAPS)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .taps_i (taps_i),
    .pol_i  (pol_i),
    .hot_q  (hot),
    .pol_q  (pol_s1)
  );

  bte_segcount #(.NTAPS(NTAPS), .SEG_W(SEG_W)) u_segcount (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_i     (hot),
    .pol_i     (pol_s1),
    .seg_cnt_q (seg_cnt),
    .seg_hit_q (seg_hit),
    .pol_q     (pol_s2)
  );

  // Segment-level running adder: add each segment count until the first
  // segment that holds a hit has been added, then add nothing more.
  function automatic logic [OUT_W-1:0] seg_combine(
    input logic [NSEG-1:0][SEG_CW-1:0] cnt,
    input logic [NSEG-1:0]             hit,
    input logic                        pol
  );
    logic [OUT_W-1:0] acc;
    logic             stop;
    acc  = pol ? OFFSET : '0;
    stop = 1'b0;
    for (int s = 0; s < NSEG; s++) begin
      if (!stop) acc = acc + OUT_W'(cnt[s]);
      if (hit[s]) stop = 1'b1;
    end
    return acc;
  endfunction

  assign total   = seg_combine(seg_cnt, seg_hit, pol_s2);
  assign any_hit = |seg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_num_o <= NO_EDGE;
      edge_vld_o <= 1'b0;
    end else begin
      edge_num_o <= total;
      edge_vld_o <= any_hit;
    end
  end

  // R7: the valid flag follows the detector row by exactly two stages.
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld_o == $past(|hot, 2));
  // R5: no edge gives the tap count, with or without the offset.
  assert_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_vld_o |-> (edge_num_o == NO_EDGE || edge_num_o == NO_EDGE + OFFSET));
  // R4: a found edge lies inside one polarity half.
  assert_in_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_vld_o |-> (edge_num_o < NO_EDGE ||
                    (edge_num_o >= OFFSET && edge_num_o < OFFSET + NO_EDGE)));
  // R9: the code never passes the top of the two halves.
  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_num_o < OUT_W'(2 * POL_OFFSET));
  // R6: the offset half is used exactly when polarity 1 was presented.
  assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_num_o >= OFFSET) == $past(pol_s1, 2));
endmodule

// File: tb/bubble_edge_encoder_test.sv
`timescale 1ns/1ps
module bubble_edge_encoder_test;
  localparam int NT  = 12;
  localparam int SW  = 4;
  localparam int OFF = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] taps = '0;
  logic          pol = 1'b0;
  logic [15:0]   edge_num;
  logic          edge_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bubble_edge_encoder #(.NTAPS(NT), .SEG_W(SW), .POL_OFFSET(OFF), .OUT_W(16)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .taps_i     (taps),
    .pol_i      (pol),
    .edge_num_o (edge_num),
    .edge_vld_o (edge_vld)
  );

  // Scan from the far end downwards; the last qualifying position seen is the lowest.
  function automatic int expect_num(input logic [NT-1:0] t, input logic p, output bit hit);
    logic [NT-1:0] x;
    int pos;
    x   = p ? ~t : t;
    pos = NT;
    hit = 0;
    for (int i = NT - 1; i >= 0; i--) begin
      bit ok;
      ok = x[i];
      for (int k = 1; k <= 4; k++)
        if (i + k < NT && x[i + k]) ok = 0;
      if (ok) begin
        pos = i;
        hit = 1;
      end
    end
    return pos + (p ? OFF : 0);
  endfunction

  function automatic int count_hits(input logic [NT-1:0] t, input logic p);
    logic [NT-1:0] x;
    int n;
    x = p ? ~t : t;
    n = 0;
    for (int i = 0; i < NT; i++) begin
      bit ok;
      ok = x[i];
      for (int k = 1; k <= 4; k++)
        if (i + k < NT && x[i + k]) ok = 0;
      if (ok) n++;
    end
    return n;
  endfunction

  task automatic check(input string tag, input int exp_num, input bit exp_vld);
    checks++;
    if (edge_num !== 16'(exp_num) || edge_vld !== exp_vld) begin
      fails++;
      $display("FAIL %s: got num=%0d vld=%0b, expected num=%0d vld=%0b",
               tag, edge_num, edge_vld, exp_num, exp_vld);
    end
  endtask

  task automatic run_one(input string tag, input logic [NT-1:0] p, input logic pl,
                         input int exp_num, input bit exp_vld);
    @(negedge clk);
    taps = p;
    pol  = pl;
    repeat (3) @(negedge clk);
    check(tag, exp_num, exp_vld);
  endtask

  initial begin
    int  q_num [4];
    bit  q_vld [4];
    string q_tag [4];
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset no-edge code", NT, 0);
    rst_n = 1'b1;

    run_one("R1 last tap padded", 12'b1000_0000_0000, 0, 11, 1);
    run_one("R1 clean thermometer", 12'b0000_0011_1111, 0, 5, 1);
    run_one("R2 zero bubble inside ones", 12'b0000_0011_1011, 0, 5, 1);
    run_one("R2 one bubble after edge", 12'b0000_1011_1111, 0, 7, 1);
    run_one("R3 two clean edges", 12'b0000_0010_0001, 0, 0, 1);
    run_one("R2 R3 bubble plus second edge", 12'b1000_0001_1011, 0, 4, 1);
    run_one("R5 all zeros", 12'b0000_0000_0000, 0, NT, 0);
    run_one("R6 inverted front", 12'b1111_1100_0000, 1, OFF + 5, 1);
    run_one("R9 upper half no edge", 12'b1111_1111_1111, 1, OFF + NT, 0);

    // R7: back-to-back snapshots, each result three edges later.
    for (int n = 0; n < 2 * (1 << NT) + 3; n++) begin
      @(negedge clk);
      if (n >= 3) check(q_tag[(n - 3) % 4], q_num[(n - 3) % 4], q_vld[(n - 3) % 4]);
      if (n < 2 * (1 << NT)) begin
        logic [NT-1:0] p;
        logic pl;
        bit h;
        p  = NT'(n % (1 << NT));
        pl = (n >= (1 << NT));
        taps = p;
        pol  = pl;
        q_num[n % 4] = expect_num(p, pl, h);
        q_vld[n % 4] = h;
        if (!h)                      q_tag[n % 4] = "R5 R7 sweep no edge";
        else if (pl)                 q_tag[n % 4] = "R6 R7 sweep polarity 1";
        else if (count_hits(p, pl) > 1) q_tag[n % 4] = "R3 R7 sweep multi edge";
        else                         q_tag[n % 4] = "R4 R7 sweep single edge";
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule